// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address by reading two translation entries from memory. A translation request arrives on a valid/ready handshake, together with the base address of the active directory. The walker splits the virtual address into a directory index, a table index and a page offset. It reads the directory entry and checks whether it is present. It then reads the table entry and checks that one too. The result goes out on a single-cycle response pulse and carries either the translated address or a fault cause.

Every entry is 32 bits wide. Bits 31:12 hold the 4 KB-aligned base of the next level: a table base in a directory entry, or a page frame in a table entry. Bit 0 is the present flag, bit 1 the used flag and bit 2 the modified flag. A directory or a table fills one 4 KB page of 1024 entries. One directory entry therefore spans 4 MB, and one table entry maps one 4 KB page. Memory is reached through a single read port: a request with valid/ready, and a response with valid after any latency. Only one walk is in progress at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: `req_ready` is 1 only while no walk is in progress. It falls in the cycle after a request is accepted and returns in the cycle after `rsp_valid`. While it is low, a waiting request is not taken.
- R3: The first read goes to (dir_base with bits 11:0 cleared) + 4 × vaddr[31:22].
- R4: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` does not change.
- R5: When the directory entry has bit 0 set, the second read goes to (directory entry with bits 11:0 cleared) + 4 × vaddr[21:12].
- R6: When both entries have bit 0 set, the response carries `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {table entry[31:12], vaddr[11:0]}.
- R7: On a successful walk, `rsp_used` equals bit 1 and `rsp_modified` equals bit 2 of the table entry. The flag bits of the directory entry are not reported.
- R8: A directory entry with bit 0 clear ends the walk with `rsp_fault`=1 and `rsp_cause`=1, and no second read is issued.
- R9: A table entry with bit 0 clear gives `rsp_fault`=1 and `rsp_cause`=2. On any fault, `rsp_paddr`, `rsp_used` and `rsp_modified` are 0.
- R10: Each accepted request produces exactly one response, and `rsp_valid` stays high for exactly one cycle.
- R11: Bits 11:0 of `dir_base` have no effect on the addresses read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Base of the active directory, sampled when a request is accepted |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | One-cycle translation result strobe |
| rsp_paddr | output | 32 | Translated physical address (0 on a fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 directory entry absent, 2 table entry absent |
| rsp_used | output | 1 | Used flag of the table entry |
| rsp_modified | output | 1 | Modified flag of the table entry |

## Verification
The bench uses the default widths: 10-bit indices and a 12-bit offset. With these it can use directory and table index 1023, an offset of 0xFFF, and a frame at 0xFFFFF000, so the adders and the concatenation are exercised up to their carry boundary. The memory model inserts random stalls and read latencies from zero to three cycles. This makes both the address-hold rule and every waiting state occur. It also presents a second request while a walk is still in progress.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

  localparam int NUM_LEVELS = 2;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_USED     = 1;
  localparam int BIT_MODIFIED = 2;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_DIR  = 2'd1;
  localparam logic [1:0] CAUSE_TBL  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_TBL,
    ST_WT_TBL,
    ST_RESP
  } walk_state_e;

endpackage

// File: rtl/ptw_entry_dec.sv
`timescale 1ns/1ps
// Splits a translation entry into its flags and the aligned next-level base.
module ptw_entry_dec #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] entry_i,
  output logic              present_o,
  output logic              used_o,
  output logic              modified_o,
  output logic [ADDR_W-1:0] base_o
);
  import ptw_pkg::*;

  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  assign present_o  = entry_i[BIT_PRESENT];
  assign used_o     = entry_i[BIT_USED];
  assign modified_o = entry_i[BIT_MODIFIED];
  assign base_o     = entry_i & ALIGN_MASK;
endmodule

// File: rtl/ptw_index_addr.sv
`timescale 1ns/1ps
// Entry address of one level: aligned base plus index scaled by entry size.
module ptw_index_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int ENT_SHIFT = $clog2(ADDR_W / 8);
  localparam int PAD_W     = ADDR_W - IDX_W - ENT_SHIFT;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic [ADDR_W-1:0] scaled;

  assign scaled = {{PAD_W{1'b0}}, idx_i, {ENT_SHIFT{1'b0}}};
  assign addr_o = (base_i & ALIGN_MASK) + scaled;
endmodule

// File: rtl/ptw_mem_req.sv
`timescale 1ns/1ps
// Read request register: holds address and valid until the memory accepts.
module ptw_mem_req #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              accepted_o
);
  assign accepted_o = mem_valid_o && mem_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid_o <= 1'b0;
      mem_addr_o  <= '0;
    end else if (issue_i) begin
      mem_valid_o <= 1'b1;
      mem_addr_o  <= issue_addr_i;
    end else if (accepted_o) begin
      mem_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker #(
  parameter  int IDX_W  = 10,
  parameter  int OFF_W  = 12,
  localparam int ADDR_W = 2 * IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic              rsp_used,
  output logic              rsp_modified
);
  import ptw_pkg::*;

  walk_state_e       state_q;
  logic [IDX_W-1:0]  tbl_idx_q;
  logic [OFF_W-1:0]  off_q;

  logic              ent_present, ent_used, ent_modified;
  logic [ADDR_W-1:0] ent_base;

  logic [ADDR_W-1:0] lvl_base [NUM_LEVELS];
  logic [IDX_W-1:0]  lvl_idx  [NUM_LEVELS];
  logic [ADDR_W-1:0] lvl_addr [NUM_LEVELS];

  logic              issue;
  logic [ADDR_W-1:0] issue_addr;
  logic              mem_acc;

  assign req_ready = (state_q == ST_IDLE);

  ptw_entry_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .entry_i    (mem_rsp_data),
    .present_o  (ent_present),
    .used_o     (ent_used),
    .modified_o (ent_modified),
    .base_o     (ent_base)
  );

  // Level 0 takes the incoming request directly; level 1 the returned entry.
  assign lvl_base[0] = dir_base;
  assign lvl_idx[0]  = req_vaddr[ADDR_W-1 -: IDX_W];
  assign lvl_base[1] = ent_base;
  assign lvl_idx[1]  = tbl_idx_q;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    ptw_index_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
      .base_i (lvl_base[g]),
      .idx_i  (lvl_idx[g]),
      .addr_o (lvl_addr[g])
    );
  end

  always_comb begin
    issue      = 1'b0;
    issue_addr = lvl_addr[0];
    if (state_q == ST_IDLE && req_valid) begin
      issue = 1'b1;
    end else if (state_q == ST_WT_DIR && mem_rsp_valid && ent_present) begin
      issue      = 1'b1;
      issue_addr = lvl_addr[1];
    end
  end

  ptw_mem_req #(.ADDR_W(ADDR_W)) u_req (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue),
    .issue_addr_i (issue_addr),
    .mem_ready_i  (mem_req_ready),
    .mem_valid_o  (mem_req_valid),
    .mem_addr_o   (mem_req_addr),
    .accepted_o   (mem_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      tbl_idx_q    <= '0;
      off_q        <= '0;
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_fault    <= 1'b0;
      rsp_cause    <= CAUSE_NONE;
      rsp_used     <= 1'b0;
      rsp_modified <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            tbl_idx_q <= req_vaddr[OFF_W +: IDX_W];
            off_q     <= req_vaddr[OFF_W-1:0];
            state_q   <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: if (mem_acc) state_q <= ST_WT_DIR;
        ST_WT_DIR: begin
          if (mem_rsp_valid) begin
            if (ent_present) begin
              state_q <= ST_RD_TBL;
            end else begin
              state_q      <= ST_RESP;
              rsp_valid    <= 1'b1;
              rsp_fault    <= 1'b1;
              rsp_cause    <= CAUSE_DIR;
              rsp_paddr    <= '0;
              rsp_used     <= 1'b0;
              rsp_modified <= 1'b0;
            end
          end
        end
        ST_RD_TBL: if (mem_acc) state_q <= ST_WT_TBL;
        ST_WT_TBL: begin
          if (mem_rsp_valid) begin
            state_q   <= ST_RESP;
            rsp_valid <= 1'b1;
            if (ent_present) begin
              rsp_fault    <= 1'b0;
              rsp_cause    <= CAUSE_NONE;
              rsp_paddr    <= {ent_base[ADDR_W-1:OFF_W], off_q};
              rsp_used     <= ent_used;
              rsp_modified <= ent_modified;
            end else begin
              rsp_fault    <= 1'b1;
              rsp_cause    <= CAUSE_TBL;
              rsp_paddr    <= '0;
              rsp_used     <= 1'b0;
              rsp_modified <= 1'b0;
            end
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [ADDR_W-1:0] dir_base,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [ADDR_W-1:0] mem_rsp_data,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause,
  input logic              rsp_used,
  input logic              rsp_modified
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !mem_req_valid && !rsp_valid));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_no_read_when_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  a_r4_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r10_not_ready_on_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r8_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

  a_r9_fault_clears_result: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_used && !rsp_modified));
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] dir_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        rsp_used;
  logic        rsp_modified;

  always #10 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_used(rsp_used), .rsp_modified(rsp_modified)
  );

  typedef struct {
    logic [31:0] paddr;
    logic        fault;
    logic [1:0]  cause;
    logic        used;
    logic        modified;
  } res_t;

  int          errors = 0;
  int          checks = 0;
  bit          finished = 0;
  logic [31:0] mem [bit [31:0]];
  res_t        exp_res [$];
  logic [31:0] exp_addr [$];
  string       exp_tag [$];

  bit          busy = 0;
  bit          acc_seen = 0;
  bit          prev_stall = 0;
  bit          heavy_stall = 0;
  logic [31:0] prev_addr = '0;
  logic [31:0] acc_addr = '0;
  bit          has_pend = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] mon_a;
  string       mon_tag;
  res_t        mon_r;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural expectation of one walk, taken from the requirements.
  task automatic expect_walk(logic [31:0] va, logic [31:0] base);
    logic [31:0] da, ta, d, t;
    res_t r;
    da = (base & 32'hFFFF_F000) + {20'd0, va[31:22], 2'b00};
    d  = rd(da);
    exp_addr.push_back(da);
    exp_tag.push_back((base[11:0] != 0) ? "R11" : "R3");
    if (!d[0]) begin
      r = '{32'h0, 1'b1, 2'd1, 1'b0, 1'b0};
    end else begin
      ta = (d & 32'hFFFF_F000) + {20'd0, va[21:12], 2'b00};
      exp_addr.push_back(ta);
      exp_tag.push_back("R5");
      t = rd(ta);
      if (!t[0]) r = '{32'h0, 1'b1, 2'd2, 1'b0, 1'b0};
      else       r = '{{t[31:12], va[11:0]}, 1'b0, 2'd0, t[1], t[2]};
    end
    exp_res.push_back(r);
  endtask

  task automatic launch(logic [31:0] va, logic [31:0] base);
    expect_walk(va, base);
    req_vaddr = va;
    dir_base  = base;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_vaddr = 32'hDEAD_BEEF;
    dir_base  = 32'h5555_5555;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (busy);
    #1;
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] base);
    launch(va, base);
    wait_idle();
  endtask

  // Monitor and reference comparison, every clock at the falling edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req_ready == !busy, "R2", "req_ready", {31'd0, req_ready}, {31'd0, !busy});
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R4", "held read request", mem_req_addr, prev_addr);
      if (mem_req_valid && mem_req_ready) begin
        acc_seen = 1;
        acc_addr = mem_req_addr;
        if (exp_addr.size() == 0) begin
          chk(0, "R8", "unexpected read", mem_req_addr, 32'h0);
        end else begin
          mon_a   = exp_addr.pop_front();
          mon_tag = exp_tag.pop_front();
          chk(mem_req_addr == mon_a, mon_tag, "entry address", mem_req_addr, mon_a);
        end
      end
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (rsp_valid) begin
        if (exp_res.size() == 0) begin
          chk(0, "R10", "unexpected response", rsp_paddr, 32'h0);
        end else begin
          mon_r = exp_res.pop_front();
          if (!mon_r.fault) begin
            chk(rsp_fault == 1'b0 && rsp_cause == 2'd0, "R6", "fault/cause", {29'd0, rsp_fault, rsp_cause}, 32'h0);
            chk(rsp_paddr == mon_r.paddr, "R6", "physical address", rsp_paddr, mon_r.paddr);
            chk(rsp_used == mon_r.used && rsp_modified == mon_r.modified, "R7", "used/modified",
                {30'd0, rsp_used, rsp_modified}, {30'd0, mon_r.used, mon_r.modified});
          end else begin
            mon_tag = (mon_r.cause == 2'd1) ? "R8" : "R9";
            chk(rsp_fault && rsp_cause == mon_r.cause, mon_tag, "fault cause",
                {29'd0, rsp_fault, rsp_cause}, {29'd0, 1'b1, mon_r.cause});
            chk(rsp_paddr == 0 && !rsp_used && !rsp_modified, "R9", "fault result zero",
                {rsp_paddr[29:0], rsp_used, rsp_modified}, 32'h0);
          end
        end
        busy = 0;
      end
      if (req_valid && req_ready) busy = 1;
    end
  end

  // Memory model: random acceptance, 0..3 cycles extra latency.
  always @(posedge clk) begin
    #1;
    mem_rsp_valid = 1'b0;
    if (rst) begin
      has_pend      = 0;
      mem_req_ready = 1'b0;
    end else begin
      if (acc_seen) begin
        has_pend  = 1;
        pend_cnt  = $urandom_range(0, 3);
        pend_addr = acc_addr;
        acc_seen  = 0;
      end
      if (has_pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_addr);
          has_pend      = 0;
        end else begin
          pend_cnt--;
        end
      end
      mem_req_ready = heavy_stall ? ($urandom_range(0, 4) == 0) : ($urandom_range(0, 2) != 0);
    end
  end

  initial begin
    // Directory at 0x0010_0000
    mem[32'h0010_0000 + 4*768]  = 32'h0020_0007;   // present, dir flags not reported
    mem[32'h0010_0000 + 4*1]    = 32'h0000_0000;   // absent
    mem[32'h0010_0000 + 4*2]    = 32'h0040_0001;
    mem[32'h0010_0000 + 4*3]    = 32'h0060_0006;   // absent with other flags
    mem[32'h0010_0000 + 4*1023] = 32'h0070_0001;
    mem[32'h0020_0000 + 4*0]    = 32'h0050_0001;
    mem[32'h0020_0000 + 4*1]    = 32'h0050_1003;
    mem[32'h0020_0000 + 4*2]    = 32'h0050_2005;
    mem[32'h0020_0000 + 4*3]    = 32'h0050_3007;
    mem[32'h0020_0000 + 4*1023] = 32'hFFFF_F007;
    mem[32'h0040_0000 + 4*5]    = 32'h1234_5006;   // absent table entry
    mem[32'h0070_0000 + 4*1023] = 32'hFFFF_F003;
    // Second directory at 0x0090_0000
    mem[32'h0090_0000 + 4*768]  = 32'h00A0_0001;
    mem[32'h00A0_0000 + 4*0]    = 32'h0B0B_0003;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'd0, req_ready}, 32'h1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'd0, mem_req_valid}, 32'h0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'h0);
    @(posedge clk); #1;

    walk(32'hC000_0ABC, 32'h0010_0000);          // R6 present-only page
    walk(32'hC000_1FFF, 32'h0010_0000);          // R7 used
    walk(32'hC000_2000, 32'h0010_0000);          // R7 modified
    walk(32'hC000_3123, 32'h0010_0ABC);          // R11 low base bits ignored
    walk(32'hC03F_F456, 32'h0010_0000);          // table index 1023
    walk(32'h0040_0000, 32'h0010_0000);          // R8 directory absent
    walk(32'h0080_5000, 32'h0010_0000);          // R9 table absent
    walk(32'h00C0_0000, 32'h0010_0FFF);          // R8 absent with flags, R11
    walk(32'hFFFF_FFFF, 32'h0010_0000);          // top corner
    walk(32'hC000_0010, 32'h0090_0FFF);          // second directory, R11

    heavy_stall = 1;                             // R4 long stalls
    walk(32'hC000_3ABC, 32'h0010_0000);
    walk(32'h0080_5FFF, 32'h0010_0000);
    heavy_stall = 0;

    launch(32'hC000_1234, 32'h0010_0000);        // R2 second request waits
    launch(32'h0040_0123, 32'h0010_0000);
    wait_idle();
    launch(32'hFFFF_F000, 32'h0010_0000);
    launch(32'hC000_2FFF, 32'h0010_0000);
    wait_idle();

    repeat (6) @(posedge clk);
    #1;
    chk(exp_addr.size() == 0, "R8", "reads left unissued", exp_addr.size(), 32'h0);
    chk(exp_res.size() == 0, "R10", "responses missing", exp_res.size(), 32'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule